// File: doc/BRIEF.md
# PWM Audio Carrier Modulator

This block turns a stream of signed audio samples into two complementary gate commands for the high-side and low-side switches of a class-D speaker stage. A free-running carrier counter counts clock cycles up to a period chosen from a fixed table of eight divisors. In each carrier period the high-side command is on while the counter is below the duty count, and the low-side command is on for the rest of the period. The duty count is half the period plus the sample scaled to half the period.

A control word sets the carrier frequency, an optional one-cycle dead gap at every switch-over, an optional random dither of one or two LSBs on the duty, and the enable. Samples arrive on a valid/ready stream. The block raises ready for exactly one cycle, the last cycle of each carrier period, and takes a sample only in that cycle. If the source holds valid low, the last sample is repeated. A new frequency selection also takes effect only at that boundary. While the block is disabled, the pad enables are low, both commands are low, the counter is held at zero and ready stays low.

Top module: `pwm_audio_mod`

## Requirements
- R1: The carrier period in clock cycles is selected by ctrl[2:0]: 0→228, 1→156, 2→76, 3→52, 4→780, 5→524, 6→396, 7→268. The s_ready pulses are exactly one period apart.
- R2: With no dither and no dead gap, the high-side command is on for D = P/2 + floor(S·P/65536) cycles per period and the low-side command for P−D cycles. Here S is the signed 16-bit sample and P the period.
- R3: s_ready is high only while enabled and only in the last cycle of a period. A sample is taken when s_valid and s_ready are both high, and it sets the duty of the next period. With s_valid low the previous sample is reused. A change of ctrl[2:0] first affects the period after the current one.
- R4: The two commands are never on together. With ctrl[3] clear, exactly one of them is on in every driven cycle.
- R5: With ctrl[3] set, each switch between the sides passes through one cycle with both commands off. In steady state this gives D−1 high-side, P−D−1 low-side and 2 dead cycles per period, for 0<D<P.
- R6: With ctrl[5:4]=1, each period's duty is D+1 or D−1, chosen pseudo-randomly.
- R7: With ctrl[5:4]=3 the duty is D+δ, with δ in {−2,−1,+1,+2}. Code 2 applies no dither.
- R8: The dithered duty saturates at 0 and at P.
- R9: With ctrl[6] clear, spk_oe is 0, both commands are 0 and s_ready is 0, and the counter is held at zero. The first s_ready after enable comes P−1 cycles after the enabling clock edge.
- R10: The control word layout is frequency select in bits 2:0, dead gap in bit 3, dither in bits 5:4 and enable in bit 6. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 7 | Control word: enable, dither, dead gap, frequency select |
| s_valid | input | 1 | Sample stream valid |
| s_data | input | 16 | Signed sample |
| s_ready | output | 1 | One-cycle pulse at the period boundary; the sample is taken when s_valid is also high |
| spk_p | output | 1 | High-side switch command, 1 = on |
| spk_n | output | 1 | Low-side switch command, 1 = on |
| spk_oe | output | 1 | Pad output enable for both commands; 0 = tri-state |

## Verification
The bench builds the block with its default parameters: 16-bit samples and a 16-bit LFSR with its default seed and taps. This brings all eight table periods within reach, from the 52-cycle shortest to the 780-cycle longest, and the full-scale sample codes that reach duty 0 and P−1. The 52-cycle period keeps the many dither and saturation windows short. Because the dither sequence depends on the seed, its checks test the allowed offset set rather than a fixed value.

// File: rtl/pwm_mod_pkg.sv
package pwm_mod_pkg;
  localparam int CNT_W = 10;

  typedef enum logic [1:0] {
    DITH_OFF = 2'd0,
    DITH_ONE = 2'd1,
    DITH_RSV = 2'd2,
    DITH_TWO = 2'd3
  } dith_e;

  typedef struct packed {
    logic       en;
    logic [1:0] dith;
    logic       dead;
    logic [2:0] fsel;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] period_of(input logic [2:0] sel);
    logic [CNT_W-1:0] p;
    case (sel)
      3'd0: p = CNT_W'(228);
      3'd1: p = CNT_W'(156);
      3'd2: p = CNT_W'(76);
      3'd3: p = CNT_W'(52);
      3'd4: p = CNT_W'(780);
      3'd5: p = CNT_W'(524);
      3'd6: p = CNT_W'(396);
      default: p = CNT_W'(268);
    endcase
    return p;
  endfunction
endpackage

// File: rtl/pwm_lfsr.sv
module pwm_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[W-2:0], ^(state & TAPS)};
  end
endmodule

// File: rtl/pwm_duty_calc.sv
module pwm_duty_calc
  import pwm_mod_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [CNT_W-1:0]           period,
  input  logic [1:0]                 mode,
  input  logic [1:0]                 rnd,
  output logic [CNT_W-1:0]           duty
);
  localparam int PW = SAMPLE_W + CNT_W + 1;
  localparam int AW = CNT_W + 3;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] half, off, dv, sum;

  always_comb begin
    prod = $signed(sample) * $signed({1'b0, period});
    off  = AW'(prod >>> SAMPLE_W);
    half = $signed({4'b0000, period[CNT_W-1:1]});
    case (dith_e'(mode))
      DITH_ONE: dv = rnd[0] ? AW'(1) : AW'(-1);
      DITH_TWO: begin
        case (rnd)
          2'b00:   dv = AW'(-2);
          2'b01:   dv = AW'(-1);
          2'b10:   dv = AW'(1);
          default: dv = AW'(2);
        endcase
      end
      default:  dv = '0;
    endcase
    sum = half + off + dv;
    if (sum < 0)                                duty = '0;
    else if (sum > $signed({3'b000, period}))   duty = period;
    else                                        duty = sum[CNT_W-1:0];
  end
endmodule

// File: rtl/pwm_carrier.sv
module pwm_carrier
  import pwm_mod_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrl_t               cfg,
  input  logic [1:0]          rnd,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  output logic                raw_hi,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [CNT_W-1:0]    per_o
);
  localparam logic [CNT_W-1:0] RST_PER  = period_of(3'd0);
  localparam logic [CNT_W-1:0] RST_DUTY = RST_PER >> 1;

  logic [CNT_W-1:0]           cnt_q, per_q, duty_q, per_nx, duty_nx;
  logic signed [SAMPLE_W-1:0] samp_q, samp_nx, calc_s;
  logic [1:0]                 calc_m;
  logic                       boundary, take;

  assign boundary = cfg.en && (cnt_q == per_q - CNT_W'(1));
  assign take     = boundary && s_valid;
  assign samp_nx  = take ? $signed(s_data) : samp_q;
  assign per_nx   = period_of(cfg.fsel);
  assign calc_s   = cfg.en ? samp_nx : '0;
  assign calc_m   = cfg.en ? cfg.dith : DITH_OFF;

  pwm_duty_calc #(.SAMPLE_W(SAMPLE_W)) u_duty (
    .sample (calc_s),
    .period (per_nx),
    .mode   (calc_m),
    .rnd    (rnd),
    .duty   (duty_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= RST_PER;
      duty_q <= RST_DUTY;
      samp_q <= '0;
    end else if (!cfg.en) begin
      cnt_q  <= '0;
      per_q  <= per_nx;
      duty_q <= duty_nx;
      samp_q <= '0;
    end else if (boundary) begin
      cnt_q  <= '0;
      per_q  <= per_nx;
      duty_q <= duty_nx;
      samp_q <= samp_nx;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign s_ready = boundary;
  assign raw_hi  = cnt_q < duty_q;
  assign cnt_o   = cnt_q;
  assign per_o   = per_q;
endmodule

// File: rtl/pwm_gate_drv.sv
module pwm_gate_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dead,
  input  logic raw_hi,
  output logic drv_p,
  output logic drv_n,
  output logic drv_oe
);
  logic last_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_hi <= 1'b0;
      drv_p   <= 1'b0;
      drv_n   <= 1'b0;
      drv_oe  <= 1'b0;
    end else if (!en) begin
      last_hi <= 1'b0;
      drv_p   <= 1'b0;
      drv_n   <= 1'b0;
      drv_oe  <= 1'b0;
    end else begin
      last_hi <= raw_hi;
      drv_p   <= raw_hi && (!dead || last_hi);
      drv_n   <= !raw_hi && (!dead || !last_hi);
      drv_oe  <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_audio_mod.sv
module pwm_audio_mod
  import pwm_mod_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [6:0]          ctrl,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  output logic                spk_p,
  output logic                spk_n,
  output logic                spk_oe
);
  localparam int HALF = LFSR_W / 2;

  ctrl_t             cfg;
  logic [LFSR_W-1:0] lfsr_st;
  logic [1:0]        rnd;
  logic              raw_hi;
  logic [CNT_W-1:0]  car_cnt, car_per;

  assign cfg = ctrl_t'(ctrl);
  assign rnd = {^lfsr_st[LFSR_W-1:HALF], ^lfsr_st[HALF-1:0]};

  pwm_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr_st)
  );

  pwm_carrier #(.SAMPLE_W(SAMPLE_W)) u_car (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cfg),
    .rnd     (rnd),
    .s_valid (s_valid),
    .s_data  (s_data),
    .s_ready (s_ready),
    .raw_hi  (raw_hi),
    .cnt_o   (car_cnt),
    .per_o   (car_per)
  );

  pwm_gate_drv u_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg.en),
    .dead   (cfg.dead),
    .raw_hi (raw_hi),
    .drv_p  (spk_p),
    .drv_n  (spk_n),
    .drv_oe (spk_oe)
  );
endmodule

// File: rtl/pwm_audio_mod_chk.sv
module pwm_audio_mod_chk
  import pwm_mod_pkg::*;
#(
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [6:0]        ctrl,
  input logic              s_ready,
  input logic              spk_p,
  input logic              spk_n,
  input logic              spk_oe,
  input logic [CNT_W-1:0]  car_cnt,
  input logic [CNT_W-1:0]  car_per,
  input logic [LFSR_W-1:0] lfsr_st
);
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(spk_p && spk_n));

  a_r4_one_side_on: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_oe && !$past(ctrl[3])) |-> (spk_p ^ spk_n));

  a_r5_gap_hi_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[3]) && $past(spk_p)) |-> !spk_n);

  a_r5_gap_lo_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[3]) && $past(spk_n)) |-> !spk_p);

  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !spk_oe |-> (!spk_p && !spk_n));

  a_r9_counter_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[6] |=> (car_cnt == '0));

  a_r3_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> ctrl[6]);

  a_r3_ready_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> (car_cnt == '0));

  a_r1_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    car_cnt < car_per);

  a_r6_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_st != '0);
endmodule

bind pwm_audio_mod pwm_audio_mod_chk #(.LFSR_W(LFSR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl    (ctrl),
  .s_ready (s_ready),
  .spk_p   (spk_p),
  .spk_n   (spk_n),
  .spk_oe  (spk_oe),
  .car_cnt (car_cnt),
  .car_per (car_per),
  .lfsr_st (lfsr_st)
);

// File: tb/pwm_audio_mod_bench.sv
module pwm_audio_mod_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]         fsel;
    logic signed [15:0] smp;
    logic               dt;
    int                 per;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 16'sd0,      1'b0, 228},
    '{3'd1, 16'sd16384,  1'b0, 156},
    '{3'd2, -16'sd32768, 1'b0, 76},
    '{3'd3, 16'sd32767,  1'b0, 52},
    '{3'd4, -16'sd16384, 1'b0, 780},
    '{3'd5, 16'sd1000,   1'b1, 524},
    '{3'd6, -16'sd1000,  1'b1, 396},
    '{3'd7, 16'sd12345,  1'b1, 268}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ctrl = '0;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic        s_ready, spk_p, spk_n, spk_oe;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_audio_mod u_pwm_audio_mod (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .spk_p(spk_p), .spk_n(spk_n), .spk_oe(spk_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_duty(input int per, input int s);
    longint prod = longint'(s) * longint'(per);
    return per / 2 + int'(prod >>> 16);
  endfunction

  task automatic set_ctrl(input bit en, input logic [1:0] dith, input bit dt, input logic [2:0] fsel);
    ctrl = {en, dith, dt, fsel};
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!s_ready) @(negedge clk);
  endtask

  task automatic measure(output int pc, output int nc, output int dc, output int pm);
    pc = 0; nc = 0; dc = 0; pm = 0;
    wait_ready();
    @(negedge clk);
    for (int j = 2; j < 2000; j++) begin
      @(negedge clk);
      if (spk_p) pc++;
      else if (spk_n) nc++;
      else dc++;
      if (s_ready && pm == 0) pm = j;
      if (pm != 0 && j == pm + 1) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pc, nc, dc, pm, d, c;
    repeat (4) @(negedge clk);
    chk(spk_oe == 1'b0, "R10 reset oe", int'(spk_oe), 0);
    chk(!spk_p && !spk_n, "R10 reset drives", int'({spk_p, spk_n}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b0, "R9 ready low while disabled", int'(s_ready), 0);
    chk(spk_oe == 1'b0, "R9 oe low while disabled", int'(spk_oe), 0);

    // Table walk: period, duty and dead gap per entry
    for (int v = 0; v < 8; v++) begin
      s_data  = VECS[v].smp;
      s_valid = 1'b1;
      set_ctrl(1'b1, 2'd0, VECS[v].dt, VECS[v].fsel);
      measure(pc, nc, dc, pm);
      measure(pc, nc, dc, pm);
      d = exp_duty(VECS[v].per, int'(VECS[v].smp));
      chk(pm == VECS[v].per, "R1 period", pm, VECS[v].per);
      if (!VECS[v].dt) begin
        chk(pc == d, "R2 high-side cycles", pc, d);
        chk(nc == VECS[v].per - d && dc == 0, "R4 low-side cycles", nc, VECS[v].per - d);
      end else begin
        chk(pc == d - 1, "R5 high-side cycles with gap", pc, d - 1);
        chk(nc == VECS[v].per - d - 1, "R5 low-side cycles with gap", nc, VECS[v].per - d - 1);
        chk(dc == 2, "R5 dead cycles", dc, 2);
      end
    end

    // R3: back-pressure reuses the last sample
    s_data = 16'sd16384; s_valid = 1'b1;
    set_ctrl(1'b1, 2'd0, 1'b0, 3'd1);
    measure(pc, nc, dc, pm);
    measure(pc, nc, dc, pm);
    chk(pc == 117, "R3 duty before hold", pc, 117);
    s_valid = 1'b0; s_data = 16'h8000;
    measure(pc, nc, dc, pm);
    measure(pc, nc, dc, pm);
    chk(pc == 117, "R3 duty held with valid low", pc, 117);
    s_valid = 1'b1;
    measure(pc, nc, dc, pm);
    chk(pc == 0, "R3 new sample after valid", pc, 0);

    // R3: frequency change waits for the boundary
    wait_ready();
    repeat (10) @(negedge clk);
    set_ctrl(1'b1, 2'd0, 1'b0, 3'd4);
    c = 10;
    do begin @(negedge clk); c++; end while (!s_ready);
    chk(c == 156, "R3 current period kept", c, 156);
    c = 0;
    do begin @(negedge clk); c++; end while (!s_ready);
    chk(c == 780, "R3 new period after boundary", c, 780);

    // R6: +/-1 dither
    s_data = 16'sd0;
    set_ctrl(1'b1, 2'd1, 1'b0, 3'd3);
    measure(pc, nc, dc, pm);
    for (int k = 0; k < 8; k++) begin
      measure(pc, nc, dc, pm);
      chk(pc == 25 || pc == 27, "R6 duty offset one", pc, 26);
      chk(pc + nc == 52, "R6 period filled", pc + nc, 52);
    end

    // R7: +/-2 dither and reserved code
    set_ctrl(1'b1, 2'd3, 1'b0, 3'd3);
    measure(pc, nc, dc, pm);
    for (int k = 0; k < 8; k++) begin
      measure(pc, nc, dc, pm);
      chk(pc >= 24 && pc <= 28 && pc != 26, "R7 duty offset two", pc, 26);
    end
    set_ctrl(1'b1, 2'd2, 1'b0, 3'd3);
    measure(pc, nc, dc, pm);
    for (int k = 0; k < 4; k++) begin
      measure(pc, nc, dc, pm);
      chk(pc == 26, "R7 reserved code no dither", pc, 26);
    end

    // R8: saturation at both ends
    s_data = 16'h8000;
    set_ctrl(1'b1, 2'd3, 1'b0, 3'd3);
    measure(pc, nc, dc, pm);
    for (int k = 0; k < 6; k++) begin
      measure(pc, nc, dc, pm);
      chk(pc <= 2 && pc + nc == 52, "R8 floor at zero", pc, 0);
    end
    s_data = 16'sd32767;
    measure(pc, nc, dc, pm);
    for (int k = 0; k < 6; k++) begin
      measure(pc, nc, dc, pm);
      chk(pc >= 49 && pc <= 52 && pc + nc == 52, "R8 ceiling at period", pc, 52);
    end

    // R9: disable and re-enable
    set_ctrl(1'b0, 2'd0, 1'b0, 3'd3);
    @(negedge clk);
    chk(spk_oe == 1'b0, "R9 oe off after disable", int'(spk_oe), 0);
    chk(!spk_p && !spk_n, "R9 drives off after disable", int'({spk_p, spk_n}), 0);
    chk(s_ready == 1'b0, "R9 no ready when disabled", int'(s_ready), 0);
    repeat (20) @(negedge clk);
    set_ctrl(1'b1, 2'd0, 1'b0, 3'd3);
    c = 0;
    do begin @(negedge clk); c++; end while (!s_ready);
    chk(c == 51, "R9 counter restarts at zero", c, 51);
    chk(spk_oe == 1'b1, "R9 oe on when enabled", int'(spk_oe), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule